// File: doc/BRIEF.md
# Zero-Compare and Bit-Test Branch Decision Unit

This block decides whether a conditional branch is taken by looking at one register value directly, with no condition-code state read or written. A single relation field, together with a kind selector, chooses one of six comparisons against zero. The operand can be read as a signed integer, a single-precision float held in the low 32 bits, or a double-precision float spanning all 64 bits. A fourth kind tests one register bit chosen by an index field.

The decision is purely combinational from the inputs. An input valid strobe passes straight through to the output strobe, and the taken flag is forced low whenever valid is low. The decode stage presents the register value, the relation code, the kind and the bit index, and samples `taken_o` in the same cycle. Target address computation and pipeline redirection happen elsewhere.

The design holds no sequential state, so it has no states or transitions. The only path through it is the combinational decision, selected by kind: compare as integer, compare as single, compare as double, or test one bit.

Top module: `branch_zero_eval`

## Requirements
- R1: With kind code 0 (integer), the 64-bit value is compared against zero as a two's-complement number. The relation codes are 0 equal, 1 not equal, 2 greater, 3 greater-or-equal, 4 less, 5 less-or-equal.
- R2: With kind code 1 (single), only bits 31:0 are interpreted (sign bit 31, exponent 30:23, mantissa 22:0). Bits 63:32 have no effect.
- R3: With kind code 2 (double), all 64 bits are interpreted (sign bit 63, exponent 62:52, mantissa 51:0). Every non-zero, non-NaN value orders by its sign alone.
- R4: For kinds 1 and 2, positive zero and negative zero both count as equal to zero, so they satisfy equal, greater-or-equal and less-or-equal.
- R5: For kinds 1 and 2, a NaN (all-ones exponent with a non-zero mantissa) makes every ordered relation and equal false, and makes not-equal true. An infinity orders by its sign.
- R6: With kind code 3 (bit test), the branch is taken exactly when bit `bit_idx_i` (0 to 63) of the value is set. The relation field is ignored.
- R7: Relation codes 6 and 7 under kinds 0 to 2 never produce a taken branch.
- R8: `valid_o` equals `valid_i` in the same cycle, and `taken_o` is low whenever `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Request strobe |
| value_i | input | 64 | Register operand |
| rel_i | input | 3 | Relation code (0..5 valid, 6..7 reserved) |
| kind_i | input | 2 | 0 integer, 1 single, 2 double, 3 bit test |
| bit_idx_i | input | 6 | Bit number for the bit test |
| valid_o | output | 1 | Result strobe, equal to valid_i |
| taken_o | output | 1 | Branch taken decision |

## Verification
The hardest cases are the float encodings at the edges: negative zero, the smallest subnormals, infinities, and NaNs that differ from infinity in only the lowest mantissa bit. Random values almost never produce these. The bench therefore builds a table that places each such pattern next to an ordinary value. It runs every table entry through all eight relation codes under each compare kind. For single kind it places unrelated upper-word bits above each low word, so that any leak from bits 63:32 changes the decision.

// File: rtl/bze_pkg.sv
package bze_pkg;
    typedef enum logic [1:0] {
        KIND_INT = 2'd0,
        KIND_SGL = 2'd1,
        KIND_DBL = 2'd2,
        KIND_BIT = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        REL_EQ   = 3'd0,
        REL_NE   = 3'd1,
        REL_GT   = 3'd2,
        REL_GE   = 3'd3,
        REL_LT   = 3'd4,
        REL_LE   = 3'd5,
        REL_RSV6 = 3'd6,
        REL_RSV7 = 3'd7
    } rel_e;
endpackage

// File: rtl/bze_fp_classify.sv
module bze_fp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              neg_o,
    output logic              zero_o,
    output logic              nan_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        exp_f  = word_i[WORD_W-2:MAN_W];
        man_f  = word_i[MAN_W-1:0];
        neg_o  = word_i[WORD_W-1];
        // Both signed zeros compare equal to zero (R4)
        zero_o = (exp_f == '0) && (man_f == '0);
        nan_o  = (&exp_f) && (man_f != '0);
    end

    always_comb begin
        a_r4_zero_not_nan: assert (!(zero_o && nan_o))
            else $error("zero and NaN flagged together");
    end
endmodule

// File: rtl/bze_rel_eval.sv
module bze_rel_eval
    import bze_pkg::*;
(
    input  logic neg_i,
    input  logic zero_i,
    input  logic nan_i,
    input  rel_e rel_i,
    output logic hit_o
);
    logic eq_f, gt_f, lt_f;

    always_comb begin
        eq_f = zero_i && !nan_i;
        gt_f = !neg_i && !zero_i && !nan_i;
        lt_f = neg_i && !zero_i && !nan_i;
        unique case (rel_i)
            REL_EQ:   hit_o = eq_f;
            REL_NE:   hit_o = !eq_f;
            REL_GT:   hit_o = gt_f;
            REL_GE:   hit_o = gt_f || eq_f;
            REL_LT:   hit_o = lt_f;
            REL_LE:   hit_o = lt_f || eq_f;
            REL_RSV6: hit_o = 1'b0;
            REL_RSV7: hit_o = 1'b0;
        endcase
    end

    always_comb begin
        a_r1_trichotomy: assert (nan_i || $onehot({eq_f, gt_f, lt_f}))
            else $error("ordering flags not exclusive");
        a_r5_nan_ordered_false: assert (!(nan_i && hit_o && rel_i != REL_NE))
            else $error("NaN satisfied a relation other than not-equal");
    end
endmodule

// File: rtl/bze_bit_pick.sv
module bze_bit_pick #(
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);
    always_comb bit_o = value_i[idx_i];
endmodule

// File: rtl/branch_zero_eval.sv
module branch_zero_eval
    import bze_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52,
    localparam int SP_W  = 1 + SP_EXP + SP_MAN,
    localparam int DP_W  = 1 + DP_EXP + DP_MAN,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic [2:0]        rel_i,
    input  logic [1:0]        kind_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic              valid_o,
    output logic              taken_o
);
    kind_e kind_s;
    rel_e  rel_s;
    logic  sp_neg, sp_zero, sp_nan;
    logic  dp_neg, dp_zero, dp_nan;
    logic  sel_neg, sel_zero, sel_nan;
    logic  cmp_hit, bit_hit, decide;

    always_comb begin
        kind_s = kind_e'(kind_i);
        rel_s  = rel_e'(rel_i);
    end

    bze_fp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp_cls (
        .word_i (value_i[SP_W-1:0]),
        .neg_o  (sp_neg),
        .zero_o (sp_zero),
        .nan_o  (sp_nan)
    );

    bze_fp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp_cls (
        .word_i (value_i[DP_W-1:0]),
        .neg_o  (dp_neg),
        .zero_o (dp_zero),
        .nan_o  (dp_nan)
    );

    always_comb begin
        unique case (kind_s)
            KIND_SGL: begin
                sel_neg = sp_neg;  sel_zero = sp_zero;  sel_nan = sp_nan;
            end
            KIND_DBL: begin
                sel_neg = dp_neg;  sel_zero = dp_zero;  sel_nan = dp_nan;
            end
            default: begin
                sel_neg  = value_i[DATA_W-1];
                sel_zero = (value_i == '0);
                sel_nan  = 1'b0;
            end
        endcase
    end

    bze_rel_eval u_rel (
        .neg_i  (sel_neg),
        .zero_i (sel_zero),
        .nan_i  (sel_nan),
        .rel_i  (rel_s),
        .hit_o  (cmp_hit)
    );

    bze_bit_pick #(.DATA_W(DATA_W)) u_bit (
        .value_i (value_i),
        .idx_i   (bit_idx_i),
        .bit_o   (bit_hit)
    );

    always_comb begin
        decide  = (kind_s == KIND_BIT) ? bit_hit : cmp_hit;
        valid_o = valid_i;
        taken_o = valid_i && decide;
    end

    always_comb begin
        a_r8_gated: assert (valid_i || !taken_o)
            else $error("taken without valid");
        a_r7_reserved: assert (!(kind_s != KIND_BIT && rel_i[2:1] == 2'b11 && taken_o))
            else $error("reserved relation taken");
        a_r6_bit_only: assert (!(kind_s == KIND_BIT && taken_o && !bit_hit))
            else $error("bit test taken with clear bit");
    end
endmodule

// File: tb/branch_zero_eval_tb.sv
module branch_zero_eval_tb;
    logic        clk = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] value_i = '0;
    logic [2:0]  rel_i = '0;
    logic [1:0]  kind_i = '0;
    logic [5:0]  bit_idx_i = '0;
    logic        valid_o, taken_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_zero_eval u_dut (
        .valid_i(valid_i), .value_i(value_i), .rel_i(rel_i),
        .kind_i(kind_i), .bit_idx_i(bit_idx_i),
        .valid_o(valid_o), .taken_o(taken_o)
    );

    logic [63:0] vals [20];

    function automatic bit expect_cmp(int kind, int rel, logic [63:0] v);
        bit sgn, zr, nn;
        if (kind == 0) begin
            sgn = v[63]; zr = (v == 0); nn = 0;
        end else if (kind == 1) begin
            sgn = v[31];
            zr  = (v[30:0] == 0);
            nn  = (v[30:0] > 31'h7F80_0000);
        end else begin
            sgn = v[63];
            zr  = (v[62:0] == 0);
            nn  = (v[62:0] > 63'h7FF0_0000_0000_0000);
        end
        if (rel > 5) return 0;
        if (nn) return (rel == 1);
        case (rel)
            0: return zr;
            1: return !zr;
            2: return !zr && !sgn;
            3: return zr || !sgn;
            4: return !zr && sgn;
            default: return zr || sgn;
        endcase
    endfunction

    task automatic check(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: kind=%0d rel=%0d idx=%0d val=%h got=%0b exp=%0b",
                     req, kind_i, rel_i, bit_idx_i, value_i, got, exp);
        end
    endtask

    task automatic apply(logic v, logic [63:0] x, int rel, int kind, int idx);
        @(negedge clk);
        valid_i = v; value_i = x; rel_i = 3'(rel); kind_i = 2'(kind); bit_idx_i = 6'(idx);
        #2;
    endtask

    initial begin
        vals[0]  = 64'h0;
        vals[1]  = 64'h8000_0000_0000_0000;
        vals[2]  = 64'hDEAD_BEEF_8000_0000;
        vals[3]  = 64'h1234_5678_0000_0001;
        vals[4]  = 64'hFFFF_FFFF_8000_0001;
        vals[5]  = 64'h0000_0000_3F80_0000;
        vals[6]  = 64'hA5A5_A5A5_BF80_0000;
        vals[7]  = 64'h0F0F_0F0F_7F80_0000;
        vals[8]  = 64'h0000_0001_FF80_0000;
        vals[9]  = 64'h8000_0000_7F80_0001;
        vals[10] = 64'h0000_0000_FFC0_0000;
        vals[11] = 64'h7FF0_0000_0000_0000;
        vals[12] = 64'hFFF0_0000_0000_0000;
        vals[13] = 64'h7FF0_0000_0000_0001;
        vals[14] = 64'hFFF8_0000_0000_0000;
        vals[15] = 64'h0000_0000_0000_0001;
        vals[16] = 64'h8000_0000_0000_0001;
        vals[17] = 64'h3FF0_0000_0000_0000;
        vals[18] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[19] = 64'h7FFF_FFFF_FFFF_FFFF;

        // R8: idle state, valid low
        apply(0, 64'h0, 0, 0, 0);
        check("R8", valid_o, 1'b0);
        check("R8", taken_o, 1'b0);

        // R1..R5, R7: every compare kind, relation and edge value
        for (int k = 0; k < 3; k++)
            for (int r = 0; r < 8; r++)
                for (int i = 0; i < 20; i++) begin
                    apply(1, vals[i], r, k, 0);
                    check("R8", valid_o, 1'b1);
                    if (r > 5)        check("R7", taken_o, 1'b0);
                    else if (k == 0)  check("R1", taken_o, expect_cmp(k, r, vals[i]));
                    else if (k == 1)  check("R2_R4_R5", taken_o, expect_cmp(k, r, vals[i]));
                    else              check("R3_R4_R5", taken_o, expect_cmp(k, r, vals[i]));
                end

        // R2: upper word toggled must not change single result
        for (int r = 0; r < 6; r++) begin
            apply(1, 64'hFFFF_FFFF_0000_0000, r, 1, 0);
            check("R2", taken_o, expect_cmp(1, r, 64'h0));
        end

        // R6: bit test across all indices, relation field varied
        for (int p = 0; p < 4; p++)
            for (int b = 0; b < 64; b++) begin
                logic [63:0] pat;
                pat = (p == 0) ? (64'h1 << b) : (p == 1) ? ~(64'h1 << b)
                    : (p == 2) ? 64'hA5C3_0F96_1234_FEDC : 64'h5A3C_F069_EDCB_0123;
                apply(1, pat, (b + p) % 8, 3, b);
                check("R6", taken_o, pat[b]);
            end

        // R8: valid low suppresses taken for every kind
        for (int k = 0; k < 4; k++) begin
            apply(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, k, 5);
            check("R8", taken_o, 1'b0);
            check("R8", valid_o, 1'b0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule